// File: doc/BRIEF.md
# Glitch-Free Core Image Loader

This block replaces the program image and the coefficient (parameter) image of a running audio processing core without audible artefacts. A single start pulse launches a fixed sequence. First it silences the converter paths through the core's control register. Next it freezes and clears the core's datapath. It then streams the program image and the parameter image, in that order, into the core's memories over a burst write port. Finally it releases every held control bit in one write.

The control register is kept as a shadow copy inside the block. Each control write changes only the hold bits and carries all other bits forward. Image words come from a ready/valid data source and pass straight through to the memory write port. The port addresses each image from zero and steps by one for every accepted beat. Both image lengths are captured when the start pulse is accepted.

Top module: `core_image_loader`

## Requirements
- R1: While reset is held and right after it, no control write, no memory write and no done pulse is presented, and the source is not given ready.
- R2: A start accepted while idle issues a first control write equal to the shadow value with bits 3 and 4 written to 0 (active-low mute of the input and output converter paths). A write held off by the register port keeps its valid and data unchanged.
- R3: The second control write additionally writes bit 2 to 0 (active-low clear of the accumulators and the data input/output registers).
- R4: After the second control write is accepted, the program image is written with select 0 at addresses 0, 1, 2, … Each beat takes the source word, and the transfer advances only on cycles where source valid and memory ready are both high.
- R5: The parameter image is written with select 1, starting again at address 0, and only after the last program beat has been accepted.
- R6: The last control write sets bits 2, 3 and 4 to 1 together. Every other bit keeps the value set at reset (parameter CTRL_INIT).
- R7: Done is high for exactly one cycle, in the cycle after the release write is accepted.
- R8: A start pulse while a load is running has no effect on the sequence. Lengths presented after the start has been accepted are ignored.
- R9: An image length of zero skips that image's burst entirely.
- R10: No memory write is presented unless the most recently accepted control write holds bits 2, 3 and 4 at 0.
- R11: Control writes and memory writes are never presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| prog_len_i | input | ADDR_W+1 | Program image length in words, sampled at start |
| param_len_i | input | ADDR_W+1 | Parameter image length in words, sampled at start |
| src_valid_i | input | 1 | Source word available |
| src_data_i | input | DATA_W | Source word |
| src_ready_o | output | 1 | Source word taken when valid is also high |
| reg_wr_valid_o | output | 1 | Control register write request |
| reg_wr_data_o | output | CTRL_W | Control register value to write |
| reg_wr_ready_i | input | 1 | Control register write accepted |
| mem_wr_valid_o | output | 1 | Memory write beat request |
| mem_wr_sel_o | output | 1 | 0 = program memory, 1 = parameter memory |
| mem_wr_addr_o | output | ADDR_W | Word address inside the selected memory |
| mem_wr_data_o | output | DATA_W | Word to write |
| mem_wr_ready_i | input | 1 | Memory write beat accepted |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with a 4-bit address, so an image of 16 words fills the whole address range and reaches the last address. It uses a 12-bit control register whose reset value has bits 2 to 4 set and a mixed pattern elsewhere. Because of this, both the clearing of the hold bits and the preservation of the bits around them show up in the written values. Zero-length images and random stalls on all three handshakes are run. Start pulses and changing lengths are also applied while a load is in progress.

// File: rtl/core_image_loader_pkg.sv
package core_image_loader_pkg;

    localparam int CLEAR_BIT    = 2;
    localparam int MUTE_ADC_BIT = 3;
    localparam int MUTE_DAC_BIT = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MUTE,
        PH_CLEAR,
        PH_PROG,
        PH_PARAM,
        PH_RELEASE
    } phase_t;

    typedef enum logic [1:0] {
        OP_MUTE,
        OP_CLEAR,
        OP_RELEASE
    } ctrl_op_t;

endpackage

// File: rtl/cil_ctrl_shadow.sv
module cil_ctrl_shadow
    import core_image_loader_pkg::*;
#(
    parameter int          CTRL_W    = 16,
    parameter logic [CTRL_W-1:0] CTRL_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_op_t          op_i,
    input  logic              accept_i,
    output logic [CTRL_W-1:0] wr_data_o
);
    localparam logic [CTRL_W-1:0] MUTE_MASK  = (CTRL_W'(1) << MUTE_ADC_BIT) | (CTRL_W'(1) << MUTE_DAC_BIT);
    localparam logic [CTRL_W-1:0] CLEAR_MASK = CTRL_W'(1) << CLEAR_BIT;

    typedef struct packed {
        logic [CTRL_W-1:0] value;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (op_i)
            OP_MUTE:    wr_data_o = s_q.value & ~MUTE_MASK;
            OP_CLEAR:   wr_data_o = s_q.value & ~(MUTE_MASK | CLEAR_MASK);
            default:    wr_data_o = s_q.value | MUTE_MASK | CLEAR_MASK;
        endcase
        if (accept_i) begin
            s_d.value = wr_data_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.value <= CTRL_INIT;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/cil_burst_engine.sv
module cil_burst_engine #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              src_ready_o,
    input  logic              mem_ready_i,
    output logic              mem_valid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              last_o
);
    typedef struct packed {
        logic [LEN_W-1:0] beat;
    } burst_t;

    burst_t s_d, s_q;
    logic   accept;

    always_comb begin
        s_d         = s_q;
        src_ready_o = active_i && mem_ready_i;
        mem_valid_o = active_i && src_valid_i;
        mem_addr_o  = s_q.beat[ADDR_W-1:0];
        mem_data_o  = src_data_i;
        accept      = active_i && src_valid_i && mem_ready_i;
        last_o      = accept && ((s_q.beat + LEN_W'(1)) == len_i);
        if (last_o) begin
            s_d.beat = '0;
        end else if (accept) begin
            s_d.beat = s_q.beat + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/core_image_loader.sv
module core_image_loader
    import core_image_loader_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 10,
    parameter int                CTRL_W    = 16,
    parameter logic [CTRL_W-1:0] CTRL_INIT = 16'h001C,
    localparam int               LEN_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  prog_len_i,
    input  logic [LEN_W-1:0]  param_len_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              src_ready_o,
    output logic              reg_wr_valid_o,
    output logic [CTRL_W-1:0] reg_wr_data_o,
    input  logic              reg_wr_ready_i,
    output logic              mem_wr_valid_o,
    output logic              mem_wr_sel_o,
    output logic [ADDR_W-1:0] mem_wr_addr_o,
    output logic [DATA_W-1:0] mem_wr_data_o,
    input  logic              mem_wr_ready_i,
    output logic              done_o
);
    typedef struct packed {
        phase_t           phase;
        logic [LEN_W-1:0] prog_len;
        logic [LEN_W-1:0] param_len;
        logic             done;
    } seq_t;

    seq_t             s_d, s_q;
    ctrl_op_t         op;
    logic             reg_accept;
    logic             burst_active;
    logic [LEN_W-1:0] burst_len;
    logic             burst_last;

    function automatic phase_t after_clear(input logic [LEN_W-1:0] p, input logic [LEN_W-1:0] q);
        if (p != '0)      return PH_PROG;
        else if (q != '0) return PH_PARAM;
        else              return PH_RELEASE;
    endfunction

    always_comb begin
        s_d            = s_q;
        s_d.done       = 1'b0;
        reg_wr_valid_o = (s_q.phase == PH_MUTE) || (s_q.phase == PH_CLEAR) || (s_q.phase == PH_RELEASE);
        reg_accept     = reg_wr_valid_o && reg_wr_ready_i;
        burst_active   = (s_q.phase == PH_PROG) || (s_q.phase == PH_PARAM);
        burst_len      = (s_q.phase == PH_PARAM) ? s_q.param_len : s_q.prog_len;
        mem_wr_sel_o   = (s_q.phase == PH_PARAM);
        unique case (s_q.phase)
            PH_MUTE:  op = OP_MUTE;
            PH_CLEAR: op = OP_CLEAR;
            default:  op = OP_RELEASE;
        endcase

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase     = PH_MUTE;
                    s_d.prog_len  = prog_len_i;
                    s_d.param_len = param_len_i;
                end
            end
            PH_MUTE: begin
                if (reg_accept) s_d.phase = PH_CLEAR;
            end
            PH_CLEAR: begin
                if (reg_accept) s_d.phase = after_clear(s_q.prog_len, s_q.param_len);
            end
            PH_PROG: begin
                if (burst_last) s_d.phase = (s_q.param_len != '0) ? PH_PARAM : PH_RELEASE;
            end
            PH_PARAM: begin
                if (burst_last) s_d.phase = PH_RELEASE;
            end
            default: begin
                if (reg_accept) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
        endcase
        done_o = s_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, prog_len: '0, param_len: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    cil_ctrl_shadow #(
        .CTRL_W    (CTRL_W),
        .CTRL_INIT (CTRL_INIT)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .accept_i  (reg_accept),
        .wr_data_o (reg_wr_data_o)
    );

    cil_burst_engine #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (burst_active),
        .len_i       (burst_len),
        .src_valid_i (src_valid_i),
        .src_data_i  (src_data_i),
        .src_ready_o (src_ready_o),
        .mem_ready_i (mem_wr_ready_i),
        .mem_valid_o (mem_wr_valid_o),
        .mem_addr_o  (mem_wr_addr_o),
        .mem_data_o  (mem_wr_data_o),
        .last_o      (burst_last)
    );
endmodule

// File: rtl/cil_checker.sv
module cil_checker
    import core_image_loader_pkg::*;
#(
    parameter int                CTRL_W    = 16,
    parameter int                ADDR_W    = 10,
    parameter logic [CTRL_W-1:0] CTRL_INIT = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_valid_o,
    input logic              reg_wr_ready_i,
    input logic [CTRL_W-1:0] reg_wr_data_o,
    input logic              mem_wr_valid_o,
    input logic              mem_wr_ready_i,
    input logic              mem_wr_sel_o,
    input logic [ADDR_W-1:0] mem_wr_addr_o,
    input logic              done_o
);
    logic [CTRL_W-1:0] last_q;
    logic              param_seen_q;
    logic [2:0]        hold_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q       <= CTRL_INIT;
            param_seen_q <= 1'b0;
        end else begin
            if (reg_wr_valid_o && reg_wr_ready_i) last_q <= reg_wr_data_o;
            if (done_o) param_seen_q <= 1'b0;
            else if (mem_wr_valid_o && mem_wr_sel_o) param_seen_q <= 1'b1;
        end
    end

    assign hold_bits = {last_q[MUTE_DAC_BIT], last_q[MUTE_ADC_BIT], last_q[CLEAR_BIT]};

    assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid_o && !reg_wr_ready_i) |=> (reg_wr_valid_o && $stable(reg_wr_data_o)));

    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid_o && !mem_wr_ready_i) |=>
            (!mem_wr_valid_o || ($stable(mem_wr_addr_o) && $stable(mem_wr_sel_o))));

    assert_param_after_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid_o && !mem_wr_sel_o) |-> !param_seen_q);

    assert_release_before_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(reg_wr_valid_o && reg_wr_ready_i) && hold_bits == 3'b111));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_core_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid_o |-> (hold_bits == 3'b000));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_valid_o && mem_wr_valid_o));
endmodule

bind core_image_loader cil_checker #(
    .CTRL_W    (CTRL_W),
    .ADDR_W    (ADDR_W),
    .CTRL_INIT (CTRL_INIT)
) u_cil_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_valid_o (reg_wr_valid_o),
    .reg_wr_ready_i (reg_wr_ready_i),
    .reg_wr_data_o  (reg_wr_data_o),
    .mem_wr_valid_o (mem_wr_valid_o),
    .mem_wr_ready_i (mem_wr_ready_i),
    .mem_wr_sel_o   (mem_wr_sel_o),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .done_o         (done_o)
);

// File: tb/core_image_loader_test.sv
module core_image_loader_test;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int CTRL_W = 12;
    localparam int LEN_W  = ADDR_W + 1;
    localparam logic [CTRL_W-1:0] INIT = 12'hA5D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  prog_len_i = '0;
    logic [LEN_W-1:0]  param_len_i = '0;
    logic              src_valid_i = 1'b0;
    logic [DATA_W-1:0] src_data_i = '0;
    logic              src_ready_o;
    logic              reg_wr_valid_o;
    logic [CTRL_W-1:0] reg_wr_data_o;
    logic              reg_wr_ready_i = 1'b0;
    logic              mem_wr_valid_o;
    logic              mem_wr_sel_o;
    logic [ADDR_W-1:0] mem_wr_addr_o;
    logic [DATA_W-1:0] mem_wr_data_o;
    logic              mem_wr_ready_i = 1'b0;
    logic              done_o;

    always #2.5 clk = ~clk;

    core_image_loader #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .CTRL_INIT(INIT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .prog_len_i(prog_len_i), .param_len_i(param_len_i),
        .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_ready_o(src_ready_o),
        .reg_wr_valid_o(reg_wr_valid_o), .reg_wr_data_o(reg_wr_data_o), .reg_wr_ready_i(reg_wr_ready_i),
        .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_sel_o(mem_wr_sel_o), .mem_wr_addr_o(mem_wr_addr_o),
        .mem_wr_data_o(mem_wr_data_o), .mem_wr_ready_i(mem_wr_ready_i), .done_o(done_o)
    );

    int vectors = 0;
    int fails = 0;

    // behavioural reference: 0 idle, 1 mute, 2 clear, 3 program, 4 parameter, 5 release
    int m_phase = 0;
    int m_beat = 0;
    int m_plen = 0;
    int m_qlen = 0;
    int m_shadow = int'(INIT);
    int m_done = 0;
    int seen_ctrl = int'(INIT);
    bit zero_case = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_reg();
        case (m_phase)
            1:       return m_shadow & ~32'h18;
            2:       return m_shadow & ~32'h1C;
            default: return m_shadow | 32'h1C;
        endcase
    endfunction

    // one cycle: drive after the falling edge, compare, then advance the model past the next rising edge
    task automatic tick(input int stall, input bit poke);
        int e_rv, e_mv, e_sr;
        string rtag, mtag;
        @(negedge clk);
        src_valid_i    = ($urandom_range(99) >= stall);
        mem_wr_ready_i = ($urandom_range(99) >= stall);
        reg_wr_ready_i = ($urandom_range(99) >= stall);
        src_data_i     = DATA_W'($urandom);
        start_i        = poke ? ($urandom_range(3) == 0) : 1'b0;
        if (m_phase != 0) begin
            prog_len_i  = LEN_W'($urandom);
            param_len_i = LEN_W'($urandom);
        end
        #1;
        e_rv = (m_phase == 1 || m_phase == 2 || m_phase == 5);
        e_mv = (m_phase == 3 || m_phase == 4) && src_valid_i;
        e_sr = (m_phase == 3 || m_phase == 4) && mem_wr_ready_i;
        rtag = (m_phase == 1) ? "R2" : (m_phase == 2) ? "R3" : (m_phase == 5) ? "R6" : "R11";
        if (start_i && m_phase != 0) rtag = "R8";
        mtag = zero_case ? "R9" : (m_phase == 4) ? "R5" : "R4";
        check(reg_wr_valid_o == e_rv, rtag, int'(reg_wr_valid_o), e_rv);
        if (e_rv) check(int'(reg_wr_data_o) == exp_reg(), rtag, int'(reg_wr_data_o), exp_reg());
        check(mem_wr_valid_o == e_mv, mtag, int'(mem_wr_valid_o), e_mv);
        check(src_ready_o == e_sr, mtag, int'(src_ready_o), e_sr);
        if (e_mv) begin
            check(int'(mem_wr_addr_o) == m_beat, mtag, int'(mem_wr_addr_o), m_beat);
            check(mem_wr_sel_o == (m_phase == 4), mtag, int'(mem_wr_sel_o), int'(m_phase == 4));
            check(mem_wr_data_o == src_data_i, mtag, int'(mem_wr_data_o), int'(src_data_i));
            check((seen_ctrl & 32'h1C) == 0, "R10", seen_ctrl, seen_ctrl & ~32'h1C);
        end
        check(done_o == m_done, "R7", int'(done_o), m_done);
        if (reg_wr_valid_o && reg_wr_ready_i) seen_ctrl = int'(reg_wr_data_o);
        m_done = 0;
        case (m_phase)
            0: if (start_i) begin
                m_plen = int'(prog_len_i);
                m_qlen = int'(param_len_i);
                m_phase = 1;
            end
            1, 2, 5: if (reg_wr_ready_i) begin
                m_shadow = exp_reg();
                if (m_phase == 1) m_phase = 2;
                else if (m_phase == 2) m_phase = (m_plen != 0) ? 3 : (m_qlen != 0) ? 4 : 5;
                else begin
                    m_phase = 0;
                    m_done = 1;
                end
            end
            default: if (src_valid_i && mem_wr_ready_i) begin
                m_beat++;
                if (m_beat == ((m_phase == 3) ? m_plen : m_qlen)) begin
                    m_beat = 0;
                    m_phase = (m_phase == 3 && m_qlen != 0) ? 4 : 5;
                end
            end
        endcase
    endtask

    task automatic run_load(input int plen, input int qlen, input int stall, input bit poke);
        int guard = 0;
        zero_case = (plen == 0 || qlen == 0);
        @(negedge clk);
        prog_len_i  = LEN_W'(plen);
        param_len_i = LEN_W'(qlen);
        start_i = 1'b1;
        #1;
        // idle cycle with start: no output yet besides the done pulse of a previous load
        check(reg_wr_valid_o == 1'b0, "R1", int'(reg_wr_valid_o), 0);
        m_plen = plen;
        m_qlen = qlen;
        m_phase = 1;
        m_done = 0;
        do begin
            tick(stall, poke);
            guard++;
        end while (m_done == 0 && guard < 5000);
        if (guard >= 5000) check(1'b0, "R7", 0, 1);
        tick(stall, 1'b0);  // done pulse cycle compared here
        tick(stall, 1'b0);  // and its fall
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(reg_wr_valid_o == 1'b0, "R1", int'(reg_wr_valid_o), 0);
        check(mem_wr_valid_o == 1'b0, "R1", int'(mem_wr_valid_o), 0);
        check(src_ready_o == 1'b0, "R1", int'(src_ready_o), 0);
        check(done_o == 1'b0, "R1", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(reg_wr_valid_o == 1'b0 && done_o == 1'b0, "R1", int'(reg_wr_valid_o), 0);
        run_load(5, 3, 0, 1'b0);     // R2 R3 R4 R5 R6 R7 no stalls
        run_load(4, 6, 40, 1'b0);    // stalls on every handshake
        run_load(16, 16, 25, 1'b1);  // full address span, R8 start pokes mid-load
        run_load(0, 7, 20, 1'b1);    // R9 program skipped
        run_load(9, 0, 20, 1'b0);    // R9 parameter skipped
        run_load(0, 0, 30, 1'b1);    // R9 both skipped
        run_load(2, 1, 70, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog R7 actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule